// File: doc/BRIEF.md
# Sequential Store Gathering Buffer

This block sits between a processor store port and a 64-bit memory bus, in front of a memory region that software only writes. Word stores to consecutive addresses inside one 32-byte line are collected in a local line buffer. While the line is being filled, no bus traffic takes place. A store to the last word slot ends the line. If all eight slots are then valid, the line goes out as one four-beat burst. Otherwise it goes out as single bus cycles, one per doubleword that holds data.

The buffer can also be forced out early. A synchronisation request, a prefetch-nudge request or a trap request does this. So does a gathered store that targets another line, and so does a load probe that hits the line being gathered. Reads are never served from the buffer. The load probe only tells the load path whether it may go ahead.

A store that breaks the expected word sequence, or that does not enable all four bytes, raises an error flag. The word is still kept. After a drain the buffer is empty again, and the next store may begin at any word of a new line.

Top module: `sgb_gather`

## Requirements
- R1: After reset the buffer is empty: `st_ready` = 1, `ld_ready` = 1, `m_valid` = 0 and `seq_err` = 0.
- R2: While a line is being gathered, accepted stores cause no master-port cycle.
- R3: When the store to word offset 7 leaves all eight slots valid, the line goes out as four beats with `m_burst` = 1. Each beat carries `m_addr` = the line base (byte address with bits 4:0 zero) and `m_be` = 8'hFF. Beat k carries word 2k+1 in `m_data[63:32]` and word 2k in `m_data[31:0]`. `m_last` is 1 on the fourth beat only.
- R4: A store to a different line while gathering is held off (`st_ready` = 0) until the current line has drained. It is then accepted as the first word of the new line.
- R5: A pulse on `sync_req`, `nudge_req` or `trap_req` while gathering starts a drain. In the empty state these inputs cause no bus cycle and leave `st_ready` high.
- R6: A load probe whose line address matches the buffered line gets `ld_ready` = 0 and starts a drain. It sees `ld_ready` = 1 once the buffer is empty. A probe to another line gets `ld_ready` = 1 at once and causes no drain.
- R7: A line that is not completely valid drains as single cycles with `m_burst` = 0 and `m_last` = 1, in ascending doubleword order, at `m_addr` = base + 8·k. A doubleword with both words valid uses `m_be` = 8'hFF. One with only the even word valid uses 8'h0F, and one with only the odd word valid uses 8'hF0. A doubleword with no valid word is skipped. This also covers a store to offset 7 that leaves earlier slots empty.
- R8: `seq_err` is 1 in the cycle after a store is accepted whose word offset differs from the previous offset plus one, or whose byte enables are not 4'hF. That word is still sent in the drain.
- R9: `st_ready` is 0 from the cycle a drain starts until the cycle after the master port accepts the drain's final cycle. In that cycle it is 1 again.
- R10: The first store after a drain starts a new sequence at any word offset, with `seq_err` = 0 if its byte enables are all set.
- R11: While `m_valid` = 1 and `m_ready` = 0, the master outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted when high with `st_valid` |
| st_waddr | input | AW-2 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| sync_req | input | 1 | Synchronisation drain request |
| nudge_req | input | 1 | Prefetch-nudge drain request |
| trap_req | input | 1 | Exception drain request |
| ld_valid | input | 1 | Load probe valid |
| ld_laddr | input | AW-5 | Load probe line address |
| ld_ready | output | 1 | Load may proceed |
| seq_err | output | 1 | Sequence or byte-enable error on last accepted store |
| m_valid | output | 1 | Master cycle valid |
| m_ready | input | 1 | Master cycle accepted |
| m_addr | output | AW | Master byte address |
| m_data | output | 64 | Master write data |
| m_be | output | 8 | Master byte enables |
| m_burst | output | 1 | Cycle belongs to a four-beat line burst |
| m_last | output | 1 | Final beat of the current transaction |

## Verification
The assertions take two things for granted. A store request, once raised, stays valid with stable address and data until it is accepted. The drain requests are single-cycle pulses that the environment does not repeat while a drain is running. The stimulus raises each store and holds it until `st_ready` is seen, and it pulses each drain request for exactly one cycle. It stalls the master port with a fixed `m_ready` pattern, so the stall-hold property is exercised without breaking either assumption.

// File: rtl/sgb_pkg.sv
// Shared types for the sequential store gathering buffer.
// Assumes a 32-bit store word and a 64-bit master bus (two words per beat).
package sgb_pkg;
    typedef enum logic [1:0] {
        SG_EMPTY = 2'd0,
        SG_FILL  = 2'd1,
        SG_DRAIN = 2'd2
    } sg_state_e;

    localparam int WORD_BITS = 32;
    localparam int BEAT_BITS = 2 * WORD_BITS;
endpackage

// File: rtl/sgb_line_store.sv
// Line data and per-slot valid bits.
// Writes a full word into its slot on wr_en; clr empties all valid bits.
// Assumes clr and wr_en are never asserted together (clr wins if they are).
module sgb_line_store #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [OFF_W-1:0]                 wr_off,
    input  logic [sgb_pkg::WORD_BITS-1:0]    wr_data,
    input  logic                             clr,
    output logic [WORDS-1:0][sgb_pkg::WORD_BITS-1:0] words,
    output logic [WORDS-1:0]                 vld
);
    for (genvar s = 0; s < WORDS; s++) begin : g_slot
        // Capture the word for this slot and track its valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[s] <= '0;
                vld[s]   <= 1'b0;
            end else if (clr) begin
                vld[s]   <= 1'b0;
            end else if (wr_en && wr_off == OFF_W'(s)) begin
                words[s] <= wr_data;
                vld[s]   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sgb_seq_track.sv
// Tracks the expected next word offset and flags stores that break the
// sequence or that carry partial byte enables. The flag is registered and
// appears the cycle after acceptance. Assumes 'first' marks the store that
// opens a new line.
module sgb_seq_track #(
    parameter int OFF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             first,
    input  logic [OFF_W-1:0] off,
    input  logic [3:0]       be,
    output logic             err
);
    logic [OFF_W-1:0] exp_off;
    logic             bad;

    // Decide whether the accepted store is out of order or partial.
    always_comb begin
        bad = acc && ((!first && off != exp_off) || be != 4'hF);
    end

    // Advance the expected offset and register the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_off <= '0;
            err     <= 1'b0;
        end else begin
            err <= bad;
            if (acc) exp_off <= off + OFF_W'(1);
        end
    end
endmodule

// File: rtl/sgb_drain.sv
// Drain engine: walks the doublewords of the line in ascending order.
// A fully valid line goes out as one burst; otherwise each doubleword holding
// data becomes its own single cycle and empty ones are skipped.
// Assumes the line contents and valid bits stay frozen while busy.
module sgb_drain #(
    parameter int WORDS = 8,
    parameter int AW    = 32,
    localparam int OFF_W = $clog2(WORDS),
    localparam int DW_N  = WORDS / 2,
    localparam int DW_W  = OFF_W - 1,
    localparam int LW    = AW - OFF_W - 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [WORDS-1:0]                 vld_start,
    input  logic [WORDS-1:0]                 vld,
    input  logic [WORDS-1:0][sgb_pkg::WORD_BITS-1:0] words,
    input  logic [LW-1:0]                    tag,
    output logic                             m_valid,
    input  logic                             m_ready,
    output logic [AW-1:0]                    m_addr,
    output logic [sgb_pkg::BEAT_BITS-1:0]    m_data,
    output logic [7:0]                       m_be,
    output logic                             m_burst,
    output logic                             m_last,
    output logic                             done
);
    logic [DW_N-1:0] pend;
    logic [DW_N-1:0] grp;
    logic [DW_N-1:0] sel;
    logic [DW_W-1:0] cur;
    logic            burst_q;

    for (genvar k = 0; k < DW_N; k++) begin : g_grp
        assign grp[k] = |vld_start[2*k +: 2];
    end

    // Pick the lowest doubleword still pending.
    always_comb begin
        cur = '0;
        for (int i = DW_N - 1; i >= 0; i--) begin
            if (pend[i]) cur = DW_W'(i);
        end
        sel = DW_N'(1) << cur;
    end

    // Drive the master cycle for the selected doubleword.
    always_comb begin
        m_valid = |pend;
        m_burst = burst_q;
        m_data  = {words[{cur, 1'b1}], words[{cur, 1'b0}]};
        if (burst_q) begin
            m_addr = {tag, {DW_W{1'b0}}, 3'b000};
            m_be   = 8'hFF;
            m_last = (cur == DW_W'(DW_N - 1));
        end else begin
            m_addr = {tag, cur, 3'b000};
            m_be   = {{4{vld[{cur, 1'b1}]}}, {4{vld[{cur, 1'b0}]}}};
            m_last = 1'b1;
        end
        done = m_valid && m_ready && ((pend & ~sel) == '0);
    end

    // Load the pending mask on start and retire doublewords on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            burst_q <= 1'b0;
        end else if (start) begin
            pend    <= grp;
            burst_q <= &vld_start;
        end else if (m_valid && m_ready) begin
            pend    <= pend & ~sel;
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data)
                                   && $stable(m_be) && $stable(m_last)));
    // R3
    burst_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_burst) |-> (m_be == 8'hFF));
    // R7
    single_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_burst) |-> (m_be != 8'h00 && m_last));
endmodule

// File: rtl/sgb_gather.sv
// Top of the sequential store gathering buffer.
// Gathers in-order word stores into one line, bursts a full line, and drains
// early on sync/nudge/trap, a load hit, or a store to another line.
// Assumes st_valid is held with stable address and data until accepted.
module sgb_gather #(
    parameter int AW    = 32,
    parameter int WORDS = 8,
    localparam int OFF_W    = $clog2(WORDS),
    localparam int LINE_LSB = OFF_W + 2,
    localparam int LW       = AW - LINE_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-3:0] st_waddr,
    input  logic [31:0]   st_data,
    input  logic [3:0]    st_be,
    input  logic          sync_req,
    input  logic          nudge_req,
    input  logic          trap_req,
    input  logic          ld_valid,
    input  logic [LW-1:0] ld_laddr,
    output logic          ld_ready,
    output logic          seq_err,
    output logic          m_valid,
    input  logic          m_ready,
    output logic [AW-1:0] m_addr,
    output logic [63:0]   m_data,
    output logic [7:0]    m_be,
    output logic          m_burst,
    output logic          m_last
);
    import sgb_pkg::*;

    sg_state_e                     state;
    logic [LW-1:0]                 tag;
    logic [OFF_W-1:0]              off;
    logic [LW-1:0]                 st_line;
    logic                          flush_any;
    logic                          ld_hit;
    logic                          st_miss;
    logic                          drain_trig;
    logic                          acc;
    logic                          last_wr;
    logic                          start;
    logic                          done;
    logic [WORDS-1:0]              vld;
    logic [WORDS-1:0]              vld_after;
    logic [WORDS-1:0][WORD_BITS-1:0] words;

    // Split the store address and evaluate the drain triggers.
    always_comb begin
        off        = st_waddr[OFF_W-1:0];
        st_line    = st_waddr[AW-3:OFF_W];
        flush_any  = sync_req || nudge_req || trap_req;
        ld_hit     = ld_valid && state != SG_EMPTY && ld_laddr == tag;
        st_miss    = st_valid && state == SG_FILL && st_line != tag;
        drain_trig = state == SG_FILL && (flush_any || ld_hit || st_miss);
        st_ready   = state == SG_EMPTY || (state == SG_FILL && !drain_trig);
        ld_ready   = !ld_hit;
        acc        = st_valid && st_ready;
        last_wr    = acc && off == OFF_W'(WORDS - 1);
        start      = drain_trig || last_wr;
        vld_after  = vld | (acc ? (WORDS'(1) << off) : '0);
    end

    // Sequence the empty / gathering / draining states and hold the line tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SG_EMPTY;
            tag   <= '0;
        end else begin
            unique case (state)
                SG_EMPTY: if (acc) begin
                    tag   <= st_line;
                    state <= last_wr ? SG_DRAIN : SG_FILL;
                end
                SG_FILL:  if (start) state <= SG_DRAIN;
                SG_DRAIN: if (done) state <= SG_EMPTY;
                default:  state <= SG_EMPTY;
            endcase
        end
    end

    sgb_line_store #(.WORDS(WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc),
        .wr_off  (off),
        .wr_data (st_data),
        .clr     (done),
        .words   (words),
        .vld     (vld)
    );

    sgb_seq_track #(.OFF_W(OFF_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .first (state == SG_EMPTY),
        .off   (off),
        .be    (st_be),
        .err   (seq_err)
    );

    sgb_drain #(.WORDS(WORDS), .AW(AW)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vld_start (vld_after),
        .vld       (vld),
        .words     (words),
        .tag       (state == SG_EMPTY ? st_line : tag),
        .m_valid   (m_valid),
        .m_ready   (m_ready),
        .m_addr    (m_addr),
        .m_data    (m_data),
        .m_be      (m_be),
        .m_burst   (m_burst),
        .m_last    (m_last),
        .done      (done)
    );

    // R2
    quiet_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SG_DRAIN) |-> !m_valid);
    // R9
    drain_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SG_DRAIN) |-> !st_ready);
    // R9
    reopen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> st_ready);
    // R5
    flush_starts_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SG_FILL && flush_any) |=> (state == SG_DRAIN));
    // R6
    load_hit_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SG_FILL && ld_hit) |=> (state == SG_DRAIN));
    // R4
    miss_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SG_FILL && st_miss) |=> (state == SG_DRAIN && m_valid));
endmodule

// File: tb/tb_sgb_gather.sv
`timescale 1ns/1ps
module tb_sgb_gather;
    typedef struct {
        logic [31:0] addr;
        logic [63:0] data;
        logic [7:0]  be;
        logic        burst;
        logic        last;
        logic        fin;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [29:0] st_waddr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = 4'hF;
    logic        sync_req = 1'b0, nudge_req = 1'b0, trap_req = 1'b0;
    logic        ld_valid = 1'b0;
    logic [26:0] ld_laddr = '0;
    logic        ld_ready, seq_err, m_valid, m_burst, m_last;
    logic        m_ready = 1'b1;
    logic [31:0] m_addr;
    logic [63:0] m_data;
    logic [7:0]  m_be;

    int n_chk = 0, n_bad = 0;
    beat_t q[$];

    bit [31:0] mw[8];
    bit [7:0]  mv = '0;
    bit [26:0] mline = '0;
    bit [2:0]  mexp = '0;
    bit        mempty = 1'b1;

    always #2.5 clk = ~clk;

    sgb_gather dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_waddr(st_waddr), .st_data(st_data), .st_be(st_be),
        .sync_req(sync_req), .nudge_req(nudge_req), .trap_req(trap_req),
        .ld_valid(ld_valid), .ld_laddr(ld_laddr), .ld_ready(ld_ready),
        .seq_err(seq_err), .m_valid(m_valid), .m_ready(m_ready),
        .m_addr(m_addr), .m_data(m_data), .m_be(m_be),
        .m_burst(m_burst), .m_last(m_last)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Stall pattern on the master port.
    int stall_cnt = 0;
    always @(posedge clk) begin
        #1;
        stall_cnt++;
        m_ready = (stall_cnt % 5) != 2;
    end

    // Driver side: turn the model line into expected bus cycles (R3, R7).
    task automatic push_drain();
        int lastk = 0;
        for (int k = 0; k < 4; k++) if (mv[2*k +: 2] != 0) lastk = k;
        for (int k = 0; k < 4; k++) begin
            beat_t b;
            b.data = {mw[2*k+1], mw[2*k]};
            if (mv == 8'hFF) begin
                b.addr = {mline, 5'd0}; b.be = 8'hFF; b.burst = 1'b1;
                b.last = (k == 3); b.fin = (k == 3);
                q.push_back(b);
            end else if (mv[2*k +: 2] != 0) begin
                b.addr = {mline, 2'(k), 3'd0};
                b.be = {{4{mv[2*k+1]}}, {4{mv[2*k]}}};
                b.burst = 1'b0; b.last = 1'b1; b.fin = (k == lastk);
                q.push_back(b);
            end
        end
        mv = '0;
        mempty = 1'b1;
    endtask

    // Monitor: compare every accepted master cycle with the queue head.
    logic        hold_v = 1'b0;
    logic [31:0] hold_a;
    logic [63:0] hold_d;
    logic [7:0]  hold_b;
    logic        want_ready = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (want_ready) begin
                check(st_ready === 1'b1, "R9 ready after final cycle", 64'(st_ready), 64'd1);
                want_ready = 1'b0;
            end
            if (hold_v && m_valid)
                check(m_addr === hold_a && m_data === hold_d && m_be === hold_b,
                      "R11 stall hold", m_data, hold_d);
            hold_v = m_valid && !m_ready;
            hold_a = m_addr; hold_d = m_data; hold_b = m_be;
            if (m_valid)
                check(st_ready === 1'b0, "R9 ready low in drain", 64'(st_ready), 64'd0);
            if (m_valid && m_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected bus cycle", {32'd0, m_addr}, 64'd0);
                end else begin
                    beat_t e;
                    logic [63:0] msk;
                    e = q.pop_front();
                    for (int i = 0; i < 8; i++) msk[8*i +: 8] = {8{e.be[i]}};
                    check(m_addr === e.addr && m_be === e.be && m_burst === e.burst
                          && m_last === e.last && (m_data & msk) === (e.data & msk),
                          e.burst ? "R3 burst beat" : "R7 single cycle",
                          {m_addr, 16'd0, m_be, 3'd0, m_burst, 3'd0, m_last},
                          {e.addr, 16'd0, e.be, 3'd0, e.burst, 3'd0, e.last});
                    if (e.fin) want_ready = 1'b1;
                end
            end
        end
    end

    // Issue one store, updating the model and checking seq_err (R4, R8, R10).
    task automatic do_store(input logic [31:0] baddr, input logic [31:0] d,
                            input logic [3:0] be, input string req);
        bit [2:0] off = baddr[4:2];
        bit       exp_err;
        if (!mempty && baddr[31:5] != mline) push_drain();
        exp_err = (be != 4'hF) || (!mempty && off != mexp);
        if (mempty) mline = baddr[31:5];
        mw[off] = d; mv[off] = 1'b1; mexp = off + 3'd1; mempty = 1'b0;
        if (off == 3'd7) push_drain();
        @(posedge clk); #1;
        st_valid = 1'b1; st_waddr = baddr[31:2]; st_data = d; st_be = be;
        for (int w = 0; w < 200; w++) begin
            @(negedge clk);
            if (st_ready) break;
        end
        @(posedge clk); #1;
        st_valid = 1'b0;
        check(seq_err === exp_err, req, 64'(seq_err), 64'(exp_err));
    endtask

    task automatic pulse_flush(input int which);
        if (!mempty) push_drain();
        @(posedge clk); #1;
        case (which)
            0: sync_req = 1'b1;
            1: nudge_req = 1'b1;
            default: trap_req = 1'b1;
        endcase
        @(posedge clk); #1;
        sync_req = 1'b0; nudge_req = 1'b0; trap_req = 1'b0;
    endtask

    task automatic probe(input logic [26:0] line);
        bit hit = !mempty && line == mline;
        if (hit) push_drain();
        @(posedge clk); #1;
        ld_valid = 1'b1; ld_laddr = line;
        @(negedge clk);
        check(ld_ready === !hit, "R6 probe gate", 64'(ld_ready), 64'(!hit));
        for (int w = 0; w < 200 && !ld_ready; w++) @(negedge clk);
        check(ld_ready === 1'b1, "R6 released once empty", 64'(ld_ready), 64'd1);
        @(posedge clk); #1;
        ld_valid = 1'b0;
    endtask

    task automatic settle();
        for (int w = 0; w < 400 && q.size() != 0; w++) @(negedge clk);
        check(q.size() == 0, "R3 R7 all cycles seen", 64'(q.size()), 64'd0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(st_ready === 1'b1, "R1 st_ready", 64'(st_ready), 64'd1);
        check(ld_ready === 1'b1, "R1 ld_ready", 64'(ld_ready), 64'd1);
        check(m_valid === 1'b0, "R1 m_valid", 64'(m_valid), 64'd0);
        check(seq_err === 1'b0, "R1 seq_err", 64'(seq_err), 64'd0);

        // R2 R3: full line gathers quietly then bursts
        for (int i = 0; i < 8; i++)
            do_store(32'h0000_1000 + 32'(4*i), 32'hA000_0000 + 32'(i), 4'hF, "R2 in-order store");
        settle();

        // R5: flush in empty state has no effect
        pulse_flush(2);
        pulse_flush(1);
        @(negedge clk);
        check(st_ready === 1'b1, "R5 empty flush keeps ready", 64'(st_ready), 64'd1);

        // R5 R7 R10: partial line from offset 2, then sync drain
        do_store(32'h0000_2008, 32'hB2, 4'hF, "R10 start mid-line");
        do_store(32'h0000_200C, 32'hB3, 4'hF, "R2 in-order store");
        do_store(32'h0000_2010, 32'hB4, 4'hF, "R2 in-order store");
        pulse_flush(0);
        settle();

        // R5 nudge while gathering
        do_store(32'h0000_2200, 32'hC0, 4'hF, "R10 new line");
        pulse_flush(1);
        settle();

        // R6: probe misses then hits
        do_store(32'h0000_3014, 32'hD5, 4'hF, "R10 odd start");
        do_store(32'h0000_3018, 32'hD6, 4'hF, "R2 in-order store");
        probe(27'h0000_1FF);
        probe(27'h0000_180);
        settle();

        // R8 R4 R10 R7: errors, then a store to a new line forces the drain
        do_store(32'h0000_4000, 32'hE0, 4'hF, "R10 first store");
        do_store(32'h0000_400C, 32'hE3, 4'hF, "R8 out of sequence");
        do_store(32'h0000_4010, 32'hE4, 4'h3, "R8 partial enables");
        do_store(32'h0000_4004, 32'hE1, 4'hF, "R8 backwards store");
        do_store(32'h0000_5008, 32'hF2, 4'hF, "R4 new line after drain");
        for (int i = 3; i < 8; i++)
            do_store(32'h0000_5000 + 32'(4*i), 32'hF0 + 32'(i), 4'hF, "R7 fill to last word");
        settle();

        // R5 trap while gathering
        do_store(32'h0000_6004, 32'h61, 4'hF, "R10 new line");
        pulse_flush(2);
        settle();

        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        report();
    end
endmodule